// File: doc/BRIEF.md
# Write-Forwarding General-Purpose Register File

This block is the architectural register file for an in-order pipeline. It has a single write port and two read ports, and the read ports are combinational. In any one cycle an older instruction can retire its result through the write port while the operand-fetch stage reads its sources through the two read ports. The write is committed to storage on the rising clock edge.

In the default ordering the file behaves as if write-back happens before operand fetch. When a read index matches the index being written in the same cycle, that read port returns the incoming write data and not the stored value. Because of this, a dependent instruction needs no extra stall cycle. A parameter can select the other ordering, read-before-write, in which a matching read returns the old contents and the new value is visible from the next cycle.

Register zero is hard-wired to zero. Writes that address it are dropped, and they are never forwarded. A synchronous active-high reset clears every register.

Top module: `bypass_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared. After reset, with no write in progress, every index reads zero on both ports.
- R2: A write with `wr_en` high and `wr_idx` not zero updates the addressed register at the rising edge. From the following cycle on, both read ports return the new value for that index.
- R3: Index 0 reads zero on both ports at all times. A write that addresses index 0 does not change any register.
- R4: In write-first ordering (`ORDER` = `ORDER_WRITE_FIRST`, the default), if `wr_en` is high, `wr_idx` is not zero and a read index equals `wr_idx`, that read port returns `wr_data` in the same cycle.
- R5: A write to index 0 is never forwarded. A read of index 0 returns zero even while a write to index 0 is in progress.
- R6: A read whose index differs from the index being written returns the stored contents of that register, unaffected by the concurrent write.
- R7: When `wr_en` is low, no register changes and no forwarding occurs, whatever values `wr_idx` and `wr_data` hold.
- R8: In read-first ordering (`ORDER` = `ORDER_READ_FIRST`), a read that matches the index being written returns the old contents in that cycle. The new value appears from the next cycle on.
- R9: The two read ports are independent. They may address the same register or different registers, and each follows R3 to R8 on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | IDX_W (5) | Destination register index |
| wr_data | input | DATA_W (32) | Value to write |
| rd0_idx | input | IDX_W (5) | Read port 0 register index |
| rd0_data | output | DATA_W (32) | Read port 0 value (combinational) |
| rd1_idx | input | IDX_W (5) | Read port 1 register index |
| rd1_data | output | DATA_W (32) | Read port 1 value (combinational) |

## Verification
The hardest case to produce is a same-cycle collision, where a write and a read name the same index, on each port separately. Within that case, the write to index 0 is the corner where forwarding must stay off. The stimulus covers these cases by sweeping every write index against every read index in consecutive cycles. Port 1 reads the mirrored index, so both ports see collisions, non-collisions and index 0 inside one sweep. The same sweep drives a write-first instance and a read-first instance side by side, so the two orderings are compared on identical traffic. A later sweep with the write enable held low shows that a parked write index and data leave both the stored contents and the read outputs untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Default geometry of the register file.
    localparam int unsigned NUM_REGS_DFLT = 32;
    localparam int unsigned DATA_W_DFLT   = 32;

    // Ordering between the write port and the read ports within one cycle.
    typedef enum logic {
        ORDER_WRITE_FIRST = 1'b0,
        ORDER_READ_FIRST  = 1'b1
    } rd_order_e;

    // True when a same-cycle write should be forwarded to a read port.
    function automatic bit order_forwards(rd_order_e ord);
        return (ord == ORDER_WRITE_FIRST);
    endfunction

    // Width of a register index for a given register count.
    function automatic int unsigned idx_width(int unsigned nregs);
        return (nregs > 1) ? $clog2(nregs) : 1;
    endfunction

endpackage

// File: rtl/regbank_wr_decode.sv
module regbank_wr_decode #(
    parameter int unsigned NUM_REGS = regbank_pkg::NUM_REGS_DFLT,
    parameter int unsigned IDX_W    = regbank_pkg::idx_width(NUM_REGS)
) (
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    output logic                  wr_fire,
    output logic [NUM_REGS-1:1]   wr_sel
);

    // A write counts only if it is enabled and targets a writable register.
    assign wr_fire = wr_en && (wr_idx != '0);

    // One-hot select for registers 1..NUM_REGS-1; register 0 has no select.
    for (genvar g = 1; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = wr_fire && (wr_idx == IDX_W'(g));
    end

endmodule

// File: rtl/regbank_storage.sv
module regbank_storage #(
    parameter int unsigned NUM_REGS = regbank_pkg::NUM_REGS_DFLT,
    parameter int unsigned DATA_W   = regbank_pkg::DATA_W_DFLT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_REGS-1:1]   wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     regs [NUM_REGS]
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            // Hard-wired zero register: no storage at all.
            assign regs[g] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_sel[g]) begin
                    q <= wr_data;
                end
            end
            assign regs[g] = q;
        end
    end

endmodule

// File: rtl/regbank_read_port.sv
module regbank_read_port #(
    parameter int unsigned NUM_REGS = regbank_pkg::NUM_REGS_DFLT,
    parameter int unsigned DATA_W   = regbank_pkg::DATA_W_DFLT,
    parameter int unsigned IDX_W    = regbank_pkg::idx_width(NUM_REGS),
    parameter bit          FWD      = 1'b1
) (
    input  logic [DATA_W-1:0]     regs [NUM_REGS],
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic                  wr_fire,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data
);

    logic              hit;
    logic [DATA_W-1:0] stored;

    // wr_fire already excludes index 0, so register 0 is never forwarded.
    assign hit    = wr_fire && (wr_idx == rd_idx);
    assign stored = regs[rd_idx];

    always_comb begin
        if (FWD && hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = stored;
        end
    end

endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
    parameter int unsigned           NUM_REGS = regbank_pkg::NUM_REGS_DFLT,
    parameter int unsigned           DATA_W   = regbank_pkg::DATA_W_DFLT,
    parameter regbank_pkg::rd_order_e ORDER   = regbank_pkg::ORDER_WRITE_FIRST,
    parameter int unsigned           IDX_W    = regbank_pkg::idx_width(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DATA_W-1:0] rd1_data
);

    localparam bit FWD = regbank_pkg::order_forwards(ORDER);
    localparam int unsigned NUM_RD = 2;

    logic                wr_fire;
    logic [NUM_REGS-1:1] wr_sel;
    logic [DATA_W-1:0]   regs [NUM_REGS];

    logic [IDX_W-1:0]    rd_idx_v  [NUM_RD];
    logic [DATA_W-1:0]   rd_data_v [NUM_RD];

    regbank_wr_decode #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_fire (wr_fire),
        .wr_sel  (wr_sel)
    );

    regbank_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign rd_idx_v[0] = rd0_idx;
    assign rd_idx_v[1] = rd1_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        regbank_read_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .IDX_W    (IDX_W),
            .FWD      (FWD)
        ) u_port (
            .regs    (regs),
            .rd_idx  (rd_idx_v[p]),
            .wr_fire (wr_fire),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_data (rd_data_v[p])
        );
    end

    assign rd0_data = rd_data_v[0];
    assign rd1_data = rd_data_v[1];

endmodule

// File: rtl/bypass_regfile_chk.sv
module bypass_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5,
    parameter bit          FWD    = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic [DATA_W-1:0] rd0_data,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic [DATA_W-1:0] rd1_data
);

    logic past_valid;
    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    // R1: first cycle out of reset, with no write, reads zero everywhere
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !wr_en) |-> (rd0_data == '0 && rd1_data == '0));

    // R3 / R5 / R9: index 0 reads zero on both ports
    a_r3_zero_port0: assert property (@(posedge clk) disable iff (rst)
        (rd0_idx == '0) |-> (rd0_data == '0));
    a_r3_zero_port1: assert property (@(posedge clk) disable iff (rst)
        (rd1_idx == '0) |-> (rd1_data == '0));

    // R4 / R9: same-cycle forwarding in write-first ordering
    a_r4_fwd_port0: assert property (@(posedge clk) disable iff (rst)
        (FWD && wr_en && wr_idx != '0 && rd0_idx == wr_idx) |-> (rd0_data == wr_data));
    a_r4_fwd_port1: assert property (@(posedge clk) disable iff (rst)
        (FWD && wr_en && wr_idx != '0 && rd1_idx == wr_idx) |-> (rd1_data == wr_data));

    // R2 / R8: a write is visible from the next cycle on
    a_r2_land_port0: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(wr_en) && $past(wr_idx) != '0 && rd0_idx == $past(wr_idx)
         && !(FWD && wr_en && wr_idx == rd0_idx))
        |-> (rd0_data == $past(wr_data)));

    // R6 / R7 / R8: value held while index is stable and nothing targets it
    a_r6_hold_port0: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $stable(rd0_idx) && !$past(wr_en && wr_idx == rd0_idx)
         && !(FWD && wr_en && wr_idx != '0 && wr_idx == rd0_idx))
        |-> $stable(rd0_data));
    a_r6_hold_port1: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $stable(rd1_idx) && !$past(wr_en && wr_idx == rd1_idx)
         && !(FWD && wr_en && wr_idx != '0 && wr_idx == rd1_idx))
        |-> $stable(rd1_data));

endmodule

bind bypass_regfile bypass_regfile_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .FWD    (FWD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd0_idx  (rd0_idx),
    .rd0_data (rd0_data),
    .rd1_idx  (rd1_idx),
    .rd1_data (rd1_data)
);

// File: tb/tb_bypass_regfile.sv
module tb_bypass_regfile;

    localparam int NREG = 32;
    localparam int DW   = 32;
    localparam int IW   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [IW-1:0] rd0_idx = '0;
    logic [IW-1:0] rd1_idx = '0;
    logic [DW-1:0] wf_rd0, wf_rd1, rf_rd0, rf_rd1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [NREG];
    bit            prev_en = 1'b0;
    int            prev_w  = 0;

    always #4 clk = ~clk;   // 125 MHz

    bypass_regfile #(.ORDER(regbank_pkg::ORDER_WRITE_FIRST)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_data(wf_rd0), .rd1_idx(rd1_idx), .rd1_data(wf_rd1));

    bypass_regfile #(.ORDER(regbank_pkg::ORDER_READ_FIRST)) dut_rdf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_data(rf_rd0), .rd1_idx(rd1_idx), .rd1_data(rf_rd1));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (wr_en=%0b wr_idx=%0d rd0=%0d rd1=%0d)",
                     req, act, exp, wr_en, wr_idx, rd0_idx, rd1_idx);
        end
    endtask

    function automatic string tag_for(int idx, bit fwd_dut);
        if (idx == 0) return (wr_en && wr_idx == 0) ? "R5" : "R3";
        if (wr_en && int'(wr_idx) == idx) return fwd_dut ? "R4" : "R8";
        if (prev_en && prev_w == idx) return "R2";
        if (!wr_en) return "R7";
        return "R6";
    endfunction

    function automatic logic [DW-1:0] exp_wf(int idx);
        if (wr_en && wr_idx != 0 && int'(wr_idx) == idx) return wr_data;
        return model[idx];
    endfunction

    // One cycle: drive away from the edge, check settled outputs, then commit model.
    task automatic step(input bit en, input int w, input logic [DW-1:0] d, input int r0, input int r1);
        @(negedge clk);
        wr_en = en; wr_idx = IW'(w); wr_data = d; rd0_idx = IW'(r0); rd1_idx = IW'(r1);
        #1;
        check({tag_for(r0, 1'b1), " port0 write-first"}, wf_rd0, exp_wf(r0));
        check({tag_for(r1, 1'b1), " R9 port1 write-first"}, wf_rd1, exp_wf(r1));
        check({tag_for(r0, 1'b0), " port0 read-first"}, rf_rd0, model[r0]);
        check({tag_for(r1, 1'b0), " R9 port1 read-first"}, rf_rd1, model[r1]);
        if (en && w != 0) model[w] = d;
        prev_en = en && (w != 0);
        prev_w  = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        prev_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        do_reset();

        // R1: every index reads zero after reset
        for (int i = 0; i < NREG; i++) step(1'b0, 0, '0, i, NREG - 1 - i);

        // R2/R3/R4/R5/R6/R8/R9: every write index against every read index
        for (int w = 0; w < NREG; w++) begin
            for (int r = 0; r < NREG; r++) begin
                step(1'b1, w, (DW'(w) << 24) ^ (DW'(r) << 12) ^ 32'h5A5_0F1, r, NREG - 1 - r);
            end
        end

        // R2: read back the whole file after the sweep
        for (int i = 0; i < NREG; i++) step(1'b0, 0, '0, i, (i + 7) % NREG);

        // R7: disabled write with parked index and data leaves everything untouched
        for (int i = 0; i < NREG; i++) step(1'b0, i, 32'hDEAD_BEEF, i, i);
        for (int i = 0; i < NREG; i++) step(1'b0, 0, '0, i, i);

        // R3/R5: writes to index 0 with all-ones data, reading index 0 on both ports
        for (int i = 0; i < 4; i++) step(1'b1, 0, 32'hFFFF_FFFF, 0, 0);

        // R1: reset in the middle of traffic clears everything again
        do_reset();
        for (int i = 0; i < NREG; i++) step(1'b0, 0, '0, i, NREG - 1 - i);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule